// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block sits after a clock synthesizer. It gates two groups of derived clocks, a processor group and a peripheral-bus group, so that each output either reproduces its input clock or is parked low. Whether an output runs depends on two things: a per-output enable bit from a serial control register, and an active-low stop request shared by its group.

Every start or stop is tied to a free-running reference clock. That clock belongs to the peripheral-bus family and is never gated. A run/stop decision is first registered on a rising edge of the reference clock. It is then carried onto each gated output at that output's next falling edge. Because of this, an output never shows a shortened high phase.

A mode strap is captured while reset is asserted. In pin mode the two stop inputs are honoured. In always-run mode the stop inputs are ignored, and the board can use those pins as ordinary clock outputs. Each gated output has a status bit that shows whether it is currently running.

Top module: `clk_stop_gate`

## Requirements
- R1: A stopped output is held low. Its status bit reads 0 while it is stopped.
- R2: A running output equals its input clock at every instant. Every high phase it shows is a whole high phase of the input clock.
- R3: A new run/stop decision is registered on a rising edge of the reference clock. It reaches an output, and that output's status bit, at the first falling edge of that output's input clock after the register is updated, and not at any other time.
- R4: The decision for an output is 1 (run) only when its enable bit is 1 and its group's stop allowance is 1.
- R5: A stop input is passed through two reference-clock flops before it is used. A level sampled at rising edge m is reflected in the decision registered at edge m+2.
- R6: The strap is captured on every reference rising edge while reset is high, and is held after reset falls. Strap value 1 (always-run) sets both group allowances to 1, whatever the levels on the stop inputs. Strap value 0 selects pin mode.
- R7: In pin mode, the allowance of the processor group is the synchronized level of `cpu_stop_n`, and the allowance of the peripheral group is the synchronized level of `pci_stop_n`. A low level on either input stops every output of that group and no output of the other group.
- R8: While reset is high, all decisions are 0 and every output stops at its next falling edge. The two synchronizers are preset to 1 (no stop).
- R9: If a request is withdrawn before it takes effect, each output follows the latest decision at the next qualifying edge pair. No partial high pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| free_clk | input | 1 | Free-running reference clock, never gated |
| rst | input | 1 | Synchronous active-high reset, reference clock domain |
| mode_strap | input | 1 | Strap: 0 = stop inputs honoured, 1 = always run |
| cpu_stop_n | input | 1 | Active-low stop request for the processor group |
| pci_stop_n | input | 1 | Active-low stop request for the peripheral group |
| cpu_en | input | N_CPU | Per-output enable bits for the processor group |
| pci_en | input | N_PCI | Per-output enable bits for the peripheral group |
| cpu_clk_in | input | N_CPU | Ungated processor-group clocks |
| pci_clk_in | input | N_PCI | Ungated peripheral-group clocks |
| cpu_clk_out | output | N_CPU | Gated processor-group clocks |
| pci_clk_out | output | N_PCI | Gated peripheral-group clocks |
| cpu_running | output | N_CPU | Current run state of each processor output |
| pci_running | output | N_PCI | Current run state of each peripheral output |

## Verification
The hardest case to reach from the ports is a stop request that is withdrawn while it is still inside the synchronizer, or a one-cycle blip on an enable bit. In either case the gate must track the decision without shortening any high phase. The stimulus drives one-cycle pulses on a stop input and toggles an enable bit on consecutive reference cycles. The gated clocks run at phase offsets that do not line up with the reference clock, so the falling-edge handoff lands at several different points within a reference cycle. A behavioural model that delays the stop levels through a queue is compared with every output level and every status bit on each reference cycle.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/10ps
package clk_stop_pkg;

    // Strap value captured during reset
    typedef enum logic {
        STRAP_PINS       = 1'b0,
        STRAP_ALWAYS_RUN = 1'b1
    } strap_e;

    // Group-level permission to run
    typedef struct packed {
        logic cpu;
        logic pci;
    } grp_allow_t;

    localparam int SYNC_DEPTH = 2;

    function automatic logic allow_of(strap_e mode, logic stop_n_sync);
        return (mode == STRAP_ALWAYS_RUN) | stop_n_sync;
    endfunction

endpackage

// File: rtl/cs_sync.sv
`timescale 1ns/10ps
module cs_sync #(
    parameter int   DEPTH   = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= {DEPTH{RST_VAL}};
        else     stage_q <= {stage_q[DEPTH-2:0], d};
    end

    assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/cs_gate_cell.sv
`timescale 1ns/10ps
module cs_gate_cell (
    input  logic rst,
    input  logic clk_in,
    input  logic want,
    output logic clk_out,
    output logic running
);
    logic run_q;

    // Gate may change only while clk_in is low
    always_ff @(negedge clk_in) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= want;
    end

    assign clk_out = clk_in & run_q;
    assign running = run_q;

    // R8: reset seen at a falling edge stops the output by the next one
    a_r8_reset_stops: assert property (@(negedge clk_in) rst |=> !running)
        else $error("a_r8_reset_stops");

    // R1: stopped output low across the high phase of the input
    a_r1_parked_low: assert property (@(negedge clk_in) disable iff (rst)
        !running |-> !clk_out)
        else $error("a_r1_parked_low");
endmodule

// File: rtl/cs_group.sv
`timescale 1ns/10ps
module cs_group #(
    parameter int N = 2
) (
    input  logic         free_clk,
    input  logic         rst,
    input  logic         allow,
    input  logic [N-1:0] en,
    input  logic [N-1:0] clk_in,
    output logic [N-1:0] clk_out,
    output logic [N-1:0] running,
    output logic [N-1:0] want_o
);
    logic [N-1:0] want_q;

    // Decision registered on the reference rising edge
    always_ff @(posedge free_clk) begin
        if (rst) want_q <= '0;
        else     want_q <= en & {N{allow}};
    end

    assign want_o = want_q;

    for (genvar i = 0; i < N; i++) begin : g_cell
        cs_gate_cell u_cell (
            .rst     (rst),
            .clk_in  (clk_in[i]),
            .want    (want_q[i]),
            .clk_out (clk_out[i]),
            .running (running[i])
        );

        // R4: a cleared enable bit forces a stop decision
        a_r4_enable_off: assert property (@(posedge free_clk) disable iff (rst)
            !en[i] |=> !want_o[i])
            else $error("a_r4_enable_off");
    end

    // R4: without group allowance no output is asked to run
    a_r4_allow_off: assert property (@(posedge free_clk) disable iff (rst)
        !allow |=> (want_o == '0))
        else $error("a_r4_allow_off");
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/10ps
module clk_stop_gate
    import clk_stop_pkg::*;
#(
    parameter int N_CPU = 2,
    parameter int N_PCI = 3
) (
    input  logic             free_clk,
    input  logic             rst,
    input  logic             mode_strap,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic [N_CPU-1:0] cpu_en,
    input  logic [N_PCI-1:0] pci_en,
    input  logic [N_CPU-1:0] cpu_clk_in,
    input  logic [N_PCI-1:0] pci_clk_in,
    output logic [N_CPU-1:0] cpu_clk_out,
    output logic [N_PCI-1:0] pci_clk_out,
    output logic [N_CPU-1:0] cpu_running,
    output logic [N_PCI-1:0] pci_running
);
    strap_e         mode_q;
    logic           cpu_stop_s;
    logic           pci_stop_s;
    grp_allow_t     allow;
    logic [N_CPU-1:0] cpu_want;
    logic [N_PCI-1:0] pci_want;

    // Strap captured while reset is asserted, held afterwards
    always_ff @(posedge free_clk) begin
        if (rst) mode_q <= strap_e'(mode_strap);
    end

    cs_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_cpu_sync (
        .clk (free_clk), .rst (rst), .d (cpu_stop_n), .q (cpu_stop_s)
    );

    cs_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_pci_sync (
        .clk (free_clk), .rst (rst), .d (pci_stop_n), .q (pci_stop_s)
    );

    always_comb begin
        allow.cpu = allow_of(mode_q, cpu_stop_s);
        allow.pci = allow_of(mode_q, pci_stop_s);
    end

    cs_group #(.N(N_CPU)) u_cpu_grp (
        .free_clk (free_clk),
        .rst      (rst),
        .allow    (allow.cpu),
        .en       (cpu_en),
        .clk_in   (cpu_clk_in),
        .clk_out  (cpu_clk_out),
        .running  (cpu_running),
        .want_o   (cpu_want)
    );

    cs_group #(.N(N_PCI)) u_pci_grp (
        .free_clk (free_clk),
        .rst      (rst),
        .allow    (allow.pci),
        .en       (pci_en),
        .clk_in   (pci_clk_in),
        .clk_out  (pci_clk_out),
        .running  (pci_running),
        .want_o   (pci_want)
    );

    // R6: strap does not move once reset has been released
    a_r6_strap_held: assert property (@(posedge free_clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q))
        else $error("a_r6_strap_held");

    // R6: in always-run mode the decision follows the enable bits alone
    a_r6_pins_ignored: assert property (@(posedge free_clk) disable iff (rst)
        (mode_q == STRAP_ALWAYS_RUN) |=> (cpu_want == $past(cpu_en)) && (pci_want == $past(pci_en)))
        else $error("a_r6_pins_ignored");

    // R5/R7: a low stop level two edges back stops the whole group
    a_r5_cpu_sync_delay: assert property (@(posedge free_clk) disable iff (rst)
        (mode_q == STRAP_PINS && !$past(rst) && !$past(rst, 2) && !$past(cpu_stop_n, 2))
        |=> (cpu_want == '0))
        else $error("a_r5_cpu_sync_delay");

    a_r7_pci_group_stop: assert property (@(posedge free_clk) disable iff (rst)
        (mode_q == STRAP_PINS && !$past(rst) && !$past(rst, 2) && !$past(pci_stop_n, 2))
        |=> (pci_want == '0))
        else $error("a_r7_pci_group_stop");
endmodule

// File: tb/clk_stop_gate_tb_top.sv
`timescale 1ns/10ps
module clk_stop_gate_tb_top;
    localparam int N_CPU = 2;
    localparam int N_PCI = 3;

    logic free_clk = 1'b0;
    always #2 free_clk = ~free_clk;   // 250 MHz reference

    // Gated-group clocks with edges off the integer grid
    logic c0 = 1'b0, c1 = 1'b0, p0 = 1'b0, p1 = 1'b1, p2 = 1'b0;
    initial begin #1.25; forever begin c0 = ~c0; #3; end end
    initial begin #1.75; forever begin c1 = ~c1; #3; end end
    initial begin #0.5;  forever begin p0 = ~p0; #2; end end
    initial begin #0.5;  forever begin p1 = ~p1; #2; end end
    initial begin #1.5;  forever begin p2 = ~p2; #2; end end

    logic [N_CPU-1:0] cpu_clk_in;
    logic [N_PCI-1:0] pci_clk_in;
    assign cpu_clk_in = {c1, c0};
    assign pci_clk_in = {p2, p1, p0};

    logic rst = 1'b1, mode_strap = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
    logic [N_CPU-1:0] cpu_en = '1;
    logic [N_PCI-1:0] pci_en = '1;
    logic [N_CPU-1:0] cpu_clk_out, cpu_running;
    logic [N_PCI-1:0] pci_clk_out, pci_running;

    clk_stop_gate #(.N_CPU(N_CPU), .N_PCI(N_PCI)) dut_i (
        .free_clk (free_clk), .rst (rst), .mode_strap (mode_strap),
        .cpu_stop_n (cpu_stop_n), .pci_stop_n (pci_stop_n),
        .cpu_en (cpu_en), .pci_en (pci_en),
        .cpu_clk_in (cpu_clk_in), .pci_clk_in (pci_clk_in),
        .cpu_clk_out (cpu_clk_out), .pci_clk_out (pci_clk_out),
        .cpu_running (cpu_running), .pci_running (pci_running)
    );

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R8";

    // ---------------- behavioural reference model ----------------
    logic m_mode;
    logic cq[$];
    logic pq[$];
    logic m_cpu_want [N_CPU];
    logic m_pci_want [N_PCI];
    logic m_cpu_run  [N_CPU];
    logic m_pci_run  [N_PCI];

    initial begin
        for (int i = 0; i < N_CPU; i++) begin m_cpu_want[i] = 1'b0; m_cpu_run[i] = 1'b0; end
        for (int i = 0; i < N_PCI; i++) begin m_pci_want[i] = 1'b0; m_pci_run[i] = 1'b0; end
        m_mode = 1'b0;
    end

    always @(posedge free_clk) begin
        logic cd, pd, ca, pa;
        if (rst) begin
            m_mode <= mode_strap;
            cq = '{1'b1, 1'b1};
            pq = '{1'b1, 1'b1};
            for (int i = 0; i < N_CPU; i++) m_cpu_want[i] <= 1'b0;
            for (int i = 0; i < N_PCI; i++) m_pci_want[i] <= 1'b0;
        end else begin
            cd = cq.pop_front(); cq.push_back(cpu_stop_n);
            pd = pq.pop_front(); pq.push_back(pci_stop_n);
            ca = m_mode | cd;
            pa = m_mode | pd;
            for (int i = 0; i < N_CPU; i++) m_cpu_want[i] <= cpu_en[i] & ca;
            for (int i = 0; i < N_PCI; i++) m_pci_want[i] <= pci_en[i] & pa;
        end
    end

    for (genvar i = 0; i < N_CPU; i++) begin : g_mc
        always @(negedge cpu_clk_in[i]) m_cpu_run[i] <= rst ? 1'b0 : m_cpu_want[i];
    end
    for (genvar i = 0; i < N_PCI; i++) begin : g_mp
        always @(negedge pci_clk_in[i]) m_pci_run[i] <= rst ? 1'b0 : m_pci_want[i];
    end

    // Compare every reference cycle, away from all edges
    always @(negedge free_clk) begin
        if (!done) begin
            for (int i = 0; i < N_CPU; i++) begin
                checks++;
                if (cpu_running[i] !== m_cpu_run[i]) begin
                    failures++;
                    $display("FAIL R3 (%s) cpu_running[%0d] got=%b exp=%b t=%0t", cur_req, i, cpu_running[i], m_cpu_run[i], $time);
                end
                checks++;
                if (cpu_clk_out[i] !== (cpu_clk_in[i] & m_cpu_run[i])) begin
                    failures++;
                    $display("FAIL %s (%s) cpu_clk_out[%0d] got=%b exp=%b t=%0t", m_cpu_run[i] ? "R2" : "R1", cur_req, i, cpu_clk_out[i], cpu_clk_in[i] & m_cpu_run[i], $time);
                end
            end
            for (int i = 0; i < N_PCI; i++) begin
                checks++;
                if (pci_running[i] !== m_pci_run[i]) begin
                    failures++;
                    $display("FAIL R3 (%s) pci_running[%0d] got=%b exp=%b t=%0t", cur_req, i, pci_running[i], m_pci_run[i], $time);
                end
                checks++;
                if (pci_clk_out[i] !== (pci_clk_in[i] & m_pci_run[i])) begin
                    failures++;
                    $display("FAIL %s (%s) pci_clk_out[%0d] got=%b exp=%b t=%0t", m_pci_run[i] ? "R2" : "R1", cur_req, i, pci_clk_out[i], pci_clk_in[i] & m_pci_run[i], $time);
                end
            end
        end
    end

    // ---------------- directed checks from the requirements ----------------
    task automatic step(int n);
        repeat (n) @(posedge free_clk);
        #1;
    endtask

    task automatic expect_status(string req, logic [N_CPU-1:0] ec, logic [N_PCI-1:0] ep);
        checks++;
        if (cpu_running !== ec || pci_running !== ep) begin
            failures++;
            $display("FAIL %s status got cpu=%b pci=%b exp cpu=%b pci=%b t=%0t", req, cpu_running, pci_running, ec, ep, $time);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        step(6);
        expect_status("R8", '0, '0);
        rst = 1'b0;
        cur_req = "R4";
        step(10);
        expect_status("R4", '1, '1);
        cpu_en = 2'b10; pci_en = 3'b110;
        step(10);
        expect_status("R4", 2'b10, 3'b110);
        cpu_en = '1; pci_en = '1;
        step(10);

        cur_req = "R7";
        pci_stop_n = 1'b0;
        step(12);
        expect_status("R7", '1, '0);
        pci_stop_n = 1'b1;
        step(10);
        expect_status("R7", '1, '1);
        cpu_stop_n = 1'b0;
        step(12);
        expect_status("R7", '0, '1);
        cpu_stop_n = 1'b1;
        step(10);

        cur_req = "R5";
        pci_stop_n = 1'b0;
        step(2);
        expect_status("R5", '1, '1);   // still inside the synchronizer
        step(8);
        expect_status("R5", '1, '0);
        pci_stop_n = 1'b1;
        step(10);

        cur_req = "R9";
        pci_stop_n = 1'b0;
        step(1);
        pci_stop_n = 1'b1;
        step(8);
        expect_status("R9", '1, '1);
        for (int k = 0; k < 8; k++) begin
            cpu_en[0] = ~cpu_en[0];
            step(1);
        end
        cpu_en = '1;
        step(10);
        expect_status("R9", '1, '1);

        cur_req = "R6";
        rst = 1'b1; mode_strap = 1'b1;
        step(6);
        expect_status("R8", '0, '0);
        rst = 1'b0;
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        mode_strap = 1'b0;             // must not be recaptured
        step(12);
        expect_status("R6", '1, '1);
        cpu_en = 2'b01;
        step(10);
        expect_status("R6", 2'b01, '1);
        step(4);

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge free_clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired t=%0t", $time);
            summary();
        end
    end
endmodule